// File: doc/BRIEF.md
# Two-Level Radix Translation Walker

This block turns a 64-bit effective address into a physical address after a translation-cache miss. It walks a two-level radix tree that lives in memory. The root value supplies the base of the top-level table and its size fields. The walker makes at most two 64-bit reads through a request/response memory port, with only one read in flight at any time. Table entries sit in memory with their bytes reversed, so every word that comes back is byte-swapped before it is decoded.

A walk ends in one of two ways. A one-cycle `done` pulse carries the leaf entry in native byte order and the physical address. A one-cycle `fault` pulse carries a cause word and the faulting address. The walker checks the referenced and changed bits of the leaf but never writes them; the requester handles that fault in software. Addresses beyond the 2 GB space are rejected before any memory read.

State machine: `ST_IDLE` accepts a request. It moves to `ST_FAULT` when the root value or the address range is bad, and to `ST_TOP_REQ` otherwise. `ST_TOP_REQ` holds the read until the port accepts it, then moves to `ST_TOP_WAIT`. `ST_TOP_WAIT` moves to `ST_LEAF_REQ` on a good pointer entry and to `ST_FAULT` on a bad one. `ST_LEAF_REQ` moves to `ST_LEAF_WAIT` once the read is accepted. `ST_LEAF_WAIT` moves to `ST_DONE` on a leaf that passes its checks and to `ST_FAULT` otherwise. `ST_DONE` and `ST_FAULT` each last one cycle and return to `ST_IDLE`.

Top module: `radix_walker`

## Requirements
- R1: Out of reset the walker is idle: `req_ready` is 1, and `mem_req_valid`, `done` and `fault` are 0.
- R2: The root value is read when a request is accepted. Bits [4:0] give log2 of the top-level entry count and must equal 10. Bits [7:5] are the space-size class and must be 0. Bits [63:8] are the table base, whose low 8 bits are zero. Any other root value ends the walk with a no-translation fault (cause bit 30, 0x40000000) and no memory read.
- R3: An effective address with any bit of [63:31] set ends the walk with a no-translation fault and no memory read.
- R4: The first read goes to the root base plus the effective-address bits [30:21] times 8. Each returned word is byte-reversed before it is decoded.
- R5: The top-level entry must have bit 63 set, bit 62 clear and bits [4:0] equal to 9. Any other value ends the walk with a no-translation fault after one read.
- R6: The second read goes to the next-level base plus the effective-address bits [20:12] times 8. The next-level base is entry bits [55:8] followed by eight zero bits.
- R7: The second-level entry must have both bit 63 and bit 62 set. Any other value, including zero, gives a no-translation fault.
- R8: A leaf that passes its checks gives a `done` pulse. `leaf_pte` carries the native-order entry, and `phys_addr` is leaf bits [55:12] followed by effective-address bits [11:0].
- R9: A leaf with the privileged bit (0x008) set refuses requests that are not privileged. A load needs the read bit (0x004) and a store needs the write bit (0x002). Any such refusal is a permission fault (cause 0x08000000).
- R10: If the permission checks pass, a load needs the referenced bit (0x100), and a store needs both the referenced bit and the changed bit (0x080). A missing bit gives a reference/change fault (cause 0x00040000). A permission fault takes precedence.
- R11: Every fault raised by a store also carries the store flag (cause 0x02000000). `fault_addr` is the full requested effective address.
- R12: At most one read is in flight. While `mem_req_ready` is low, the walker holds the read request and its address unchanged.
- R13: Each accepted request gives exactly one pulse, either `done` or `fault`, lasting one cycle. The walker is back in idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_cfg | input | 64 | Root value: table base and size fields |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_ea | input | 64 | Effective address to translate |
| req_store | input | 1 | 1 for a store access, 0 for a load |
| req_priv | input | 1 | Request made in privileged mode |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, in stored (byte-reversed) order |
| done | output | 1 | One-cycle pulse: translation found |
| leaf_pte | output | 64 | Leaf entry in native order, valid with `done` |
| phys_addr | output | 64 | Translated physical address, valid with `done` |
| fault | output | 1 | One-cycle pulse: walk failed |
| fault_cause | output | 32 | Cause bits, valid with `fault` |
| fault_addr | output | 64 | Faulting effective address, valid with `fault` |

## Verification
The assertions assume that the memory side returns exactly one response for each accepted read, one or more cycles after acceptance, and never sends a response while no read is outstanding. They also assume that a requester raises `req_valid` only when it wants a walk. The bench memory model keeps to this rule: it answers each accepted read once, on the cycle after acceptance. It can also hold `mem_req_ready` low for a set number of cycles to test the hold behaviour. Table contents are written through a helper that stores each entry byte-reversed, in the same way software would.

// File: rtl/rwalk_pkg.sv
package rwalk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TOP_REQ,
        ST_TOP_WAIT,
        ST_LEAF_REQ,
        ST_LEAF_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    // Cause word bits reported with a fault
    localparam logic [31:0] CAUSE_NOTRANS = 32'h4000_0000;
    localparam logic [31:0] CAUSE_PERM    = 32'h0800_0000;
    localparam logic [31:0] CAUSE_STORE   = 32'h0200_0000;
    localparam logic [31:0] CAUSE_REFCHG  = 32'h0004_0000;

    // Entry bit positions
    localparam int E_VALID   = 63;
    localparam int E_LEAF    = 62;
    localparam int E_BASE_HI = 55;
    localparam int E_BASE_LO = 8;
    localparam int E_PPN_LO  = 12;
    localparam int E_SIZE_W  = 5;

    // Leaf attribute bit positions
    localparam int A_WRITE = 1;
    localparam int A_READ  = 2;
    localparam int A_PRIV  = 3;
    localparam int A_CHG   = 7;
    localparam int A_REF   = 8;

endpackage

// File: rtl/rwalk_byteswap.sv
module rwalk_byteswap #(
    parameter int BYTES = 8
) (
    input  logic [BYTES*8-1:0] din,
    output logic [BYTES*8-1:0] dout
);
    genvar b;
    generate
        for (b = 0; b < BYTES; b++) begin : g_lane
            assign dout[b*8 +: 8] = din[(BYTES-1-b)*8 +: 8];
        end
    endgenerate
endmodule

// File: rtl/rwalk_entry_addr.sv
module rwalk_entry_addr #(
    parameter int ADDR_W      = 64,
    parameter int IDX_BITS    = 10,
    parameter int ENTRY_SHIFT = 3
) (
    input  logic [ADDR_W-1:0]   base,
    input  logic [IDX_BITS-1:0] idx,
    output logic [ADDR_W-1:0]   addr
);
    localparam int PAD = ADDR_W - IDX_BITS;

    logic [ADDR_W-1:0] offset;

    assign offset = {{PAD{1'b0}}, idx} << ENTRY_SHIFT;
    assign addr   = base + offset;
endmodule

// File: rtl/rwalk_perm_check.sv
module rwalk_perm_check
    import rwalk_pkg::*;
(
    input  logic        is_store,
    input  logic        is_priv,
    input  logic        a_read,
    input  logic        a_write,
    input  logic        a_priv,
    input  logic        a_ref,
    input  logic        a_chg,
    output logic [31:0] cause
);
    logic access_denied;
    logic track_missing;

    always_comb begin
        access_denied = (a_priv && !is_priv) || (is_store ? !a_write : !a_read);
        track_missing = !a_ref || (is_store && !a_chg);
        cause = '0;
        if (access_denied) begin
            cause = CAUSE_PERM;
        end else if (track_missing) begin
            cause = CAUSE_REFCHG;
        end
    end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import rwalk_pkg::*;
#(
    parameter int SPACE_BITS  = 31,
    parameter int PAGE_SHIFT  = 12,
    parameter int TOP_BITS    = 10,
    parameter int LEAF_BITS   = 9,
    parameter int ENTRY_BYTES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] root_cfg,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [63:0] req_ea,
    input  logic        req_store,
    input  logic        req_priv,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [63:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [63:0] mem_rsp_data,
    output logic        done,
    output logic [63:0] leaf_pte,
    output logic [63:0] phys_addr,
    output logic        fault,
    output logic [31:0] fault_cause,
    output logic [63:0] fault_addr
);
    localparam int LEAF_LO     = PAGE_SHIFT;
    localparam int TOP_LO      = PAGE_SHIFT + LEAF_BITS;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);
    localparam logic [E_SIZE_W-1:0] TOP_SIZE  = E_SIZE_W'(TOP_BITS);
    localparam logic [E_SIZE_W-1:0] LEAF_SIZE = E_SIZE_W'(LEAF_BITS);

    walk_state_e state_q, state_d;

    logic [63:0] ea_q;
    logic        store_q;
    logic        priv_q;
    logic [63:0] top_base_q;
    logic [63:0] leaf_base_q;
    logic [63:0] pte_q;
    logic [31:0] cause_q;

    logic [63:0] rsp_word;
    logic [63:0] top_addr;
    logic [63:0] leaf_addr;
    logic        accept;
    logic        root_ok;
    logic        range_ok;
    logic        top_bad;
    logic        leaf_bad;
    logic [31:0] perm_cause;
    logic [31:0] store_flag;

    // Stored entries are byte-reversed; bring them to native order
    rwalk_byteswap #(.BYTES(ENTRY_BYTES)) u_swap (
        .din  (mem_rsp_data),
        .dout (rsp_word)
    );

    rwalk_entry_addr #(
        .ADDR_W      (64),
        .IDX_BITS    (TOP_BITS),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_top_addr (
        .base (top_base_q),
        .idx  (ea_q[TOP_LO +: TOP_BITS]),
        .addr (top_addr)
    );

    rwalk_entry_addr #(
        .ADDR_W      (64),
        .IDX_BITS    (LEAF_BITS),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_leaf_addr (
        .base (leaf_base_q),
        .idx  (ea_q[LEAF_LO +: LEAF_BITS]),
        .addr (leaf_addr)
    );

    rwalk_perm_check u_perm (
        .is_store (store_q),
        .is_priv  (priv_q),
        .a_read   (rsp_word[A_READ]),
        .a_write  (rsp_word[A_WRITE]),
        .a_priv   (rsp_word[A_PRIV]),
        .a_ref    (rsp_word[A_REF]),
        .a_chg    (rsp_word[A_CHG]),
        .cause    (perm_cause)
    );

    assign accept     = req_valid && (state_q == ST_IDLE);
    assign root_ok    = (root_cfg[E_SIZE_W-1:0] == TOP_SIZE) && (root_cfg[7:E_SIZE_W] == '0);
    assign range_ok   = (req_ea[63:SPACE_BITS] == '0);
    assign top_bad    = !rsp_word[E_VALID] || rsp_word[E_LEAF] ||
                        (rsp_word[E_SIZE_W-1:0] != LEAF_SIZE);
    assign leaf_bad   = !rsp_word[E_VALID] || !rsp_word[E_LEAF];
    assign store_flag = store_q ? CAUSE_STORE : '0;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = (root_ok && range_ok) ? ST_TOP_REQ : ST_FAULT;
                end
            end
            ST_TOP_REQ: begin
                if (mem_req_ready) state_d = ST_TOP_WAIT;
            end
            ST_TOP_WAIT: begin
                if (mem_rsp_valid) state_d = top_bad ? ST_FAULT : ST_LEAF_REQ;
            end
            ST_LEAF_REQ: begin
                if (mem_req_ready) state_d = ST_LEAF_WAIT;
            end
            ST_LEAF_WAIT: begin
                if (mem_rsp_valid) begin
                    if (leaf_bad || (perm_cause != '0)) state_d = ST_FAULT;
                    else                                state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Walk context and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q        <= '0;
            store_q     <= 1'b0;
            priv_q      <= 1'b0;
            top_base_q  <= '0;
            leaf_base_q <= '0;
            pte_q       <= '0;
            cause_q     <= '0;
        end else begin
            if (accept) begin
                ea_q       <= req_ea;
                store_q    <= req_store;
                priv_q     <= req_priv;
                top_base_q <= {root_cfg[63:8], 8'h00};
                if (!(root_ok && range_ok)) begin
                    cause_q <= CAUSE_NOTRANS | (req_store ? CAUSE_STORE : 32'h0);
                end
            end
            if (state_q == ST_TOP_WAIT && mem_rsp_valid) begin
                if (top_bad) begin
                    cause_q <= CAUSE_NOTRANS | store_flag;
                end else begin
                    leaf_base_q <= {8'h00, rsp_word[E_BASE_HI:E_BASE_LO], 8'h00};
                end
            end
            if (state_q == ST_LEAF_WAIT && mem_rsp_valid) begin
                if (leaf_bad) begin
                    cause_q <= CAUSE_NOTRANS | store_flag;
                end else if (perm_cause != '0) begin
                    cause_q <= perm_cause | store_flag;
                end else begin
                    pte_q <= rsp_word;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_TOP_REQ) || (state_q == ST_LEAF_REQ);
        mem_req_addr  = (state_q == ST_LEAF_REQ) ? leaf_addr : top_addr;
        done          = (state_q == ST_DONE);
        fault         = (state_q == ST_FAULT);
        leaf_pte      = pte_q;
        phys_addr     = {8'h00, pte_q[E_BASE_HI:E_PPN_LO], ea_q[PAGE_SHIFT-1:0]};
        fault_cause   = cause_q;
        fault_addr    = ea_q;
    end

endmodule

// File: rtl/rwalk_sva.sv
module rwalk_sva #(
    parameter int SPACE_BITS = 31
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [63:0] mem_req_addr,
    input logic        done,
    input logic [63:0] leaf_pte,
    input logic        fault,
    input logic [31:0] fault_cause,
    input logic [63:0] fault_addr
);
    // R1 / R12: no read is issued while idle
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    // R12: a stalled read keeps its request and address
    a_r12_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R4 / R6: entry reads are 8-byte aligned
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));

    // R13: done and fault are exclusive
    a_r13_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R13: single-cycle pulse, then idle
    a_r13_back_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> req_ready && !done && !fault);

    // R13: an accepted request leaves idle
    a_r13_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R8: a reported leaf is valid and marked as leaf
    a_r8_leaf_shape: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> leaf_pte[63] && leaf_pte[62]);

    // R11: a fault always names a cause
    a_r11_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_cause != 32'h0));

    // R3: out-of-range address gives no-translation
    a_r3_range_fault: assert property (@(posedge clk) disable iff (!rst_n)
        fault && (fault_addr[63:SPACE_BITS] != '0) |-> fault_cause[30]);

endmodule

bind radix_walker rwalk_sva #(.SPACE_BITS(SPACE_BITS)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .leaf_pte      (leaf_pte),
    .fault         (fault),
    .fault_cause   (fault_cause),
    .fault_addr    (fault_addr)
);

// File: tb/radix_walker_tb.sv
`timescale 1ns/1ps
module radix_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] root_cfg;
    logic        req_valid, req_ready, req_store, req_priv;
    logic [63:0] req_ea;
    logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [63:0] mem_req_addr, mem_rsp_data;
    logic        done, fault;
    logic [63:0] leaf_pte, phys_addr, fault_addr;
    logic [31:0] fault_cause;

    always #2 clk = ~clk;

    radix_walker u_dut (
        .clk(clk), .rst_n(rst_n), .root_cfg(root_cfg),
        .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
        .req_store(req_store), .req_priv(req_priv),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .leaf_pte(leaf_pte),
        .phys_addr(phys_addr), .fault(fault), .fault_cause(fault_cause),
        .fault_addr(fault_addr)
    );

    localparam logic [63:0] ROOT_BASE = 64'h1_0000;
    localparam logic [63:0] P_DFLT    = 64'h186;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [63:0] mem_q [logic [63:0]];
    logic [63:0] next_tbl;
    int          nreads;
    logic [63:0] first_addr, last_addr, stall_addr;
    int          stall_left = 0;

    logic        r_done, r_fault, r_after_ok;
    logic [63:0] r_pte, r_pa, r_faddr;
    logic [31:0] r_cause;

    function automatic logic [63:0] swap64(input logic [63:0] v);
        logic [63:0] o;
        for (int b = 0; b < 8; b++) o[b*8 +: 8] = v[(7-b)*8 +: 8];
        return o;
    endfunction

    function automatic logic [63:0] rd(input logic [63:0] a);
        if (mem_q.exists(a)) return mem_q[a];
        return 64'h0;
    endfunction

    task automatic put(input logic [63:0] a, input logic [63:0] v);
        mem_q[a] = swap64(v);
    endtask

    task automatic clear_mem();
        mem_q.delete();
        next_tbl = 64'h1_2000;
    endtask

    task automatic map(input logic [63:0] ea, input logic [63:0] pa, input logic [63:0] perm);
        logic [63:0] l1a, l2b;
        l1a = ROOT_BASE + {54'h0, ea[30:21]} * 8;
        if (!mem_q.exists(l1a)) begin
            put(l1a, 64'h8000_0000_0000_0000 | next_tbl | 64'd9);
            next_tbl = next_tbl + 64'h1000;
        end
        l2b = swap64(mem_q[l1a]) & 64'h00ff_ffff_ffff_ff00;
        put(l2b + {55'h0, ea[20:12]} * 8,
            64'hc000_0000_0000_0000 | (pa & 64'h00ff_ffff_ffff_f000) | perm);
    endtask

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Memory responder: one answer per accepted read, optional stall
    initial begin
        mem_req_ready = 1'b1;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                if (stall_left > 0) begin
                    mem_req_ready = 1'b0;
                    stall_addr    = mem_req_addr;
                    stall_left--;
                end else begin
                    mem_req_ready = 1'b1;
                    last_addr = mem_req_addr;
                    if (nreads == 0) first_addr = mem_req_addr;
                    nreads++;
                    @(negedge clk);
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(last_addr);
                end
            end else begin
                mem_req_ready = 1'b1;
            end
        end
    end

    task automatic walk(input logic [63:0] ea, input logic st, input logic pv);
        @(negedge clk);
        req_ea = ea; req_store = st; req_priv = pv; req_valid = 1'b1;
        nreads = 0; first_addr = '1; last_addr = '1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 80; k++) begin
            if (done || fault) break;
            @(negedge clk);
        end
        r_done = done; r_fault = fault; r_pte = leaf_pte; r_pa = phys_addr;
        r_cause = fault_cause; r_faddr = fault_addr;
        @(negedge clk);
        r_after_ok = !done && !fault && req_ready;
    endtask

    task automatic expect_fault(input string tag, input logic [31:0] cause, input int reads);
        chk({tag, " fault"}, {63'h0, r_fault}, 64'h1);
        chk({tag, " cause"}, {32'h0, r_cause}, {32'h0, cause});
        chk({tag, " reads"}, 64'(nreads), 64'(reads));
    endtask

    task automatic t_reset();
        chk("R1 req_ready", {63'h0, req_ready}, 64'h1);
        chk("R1 mem_req_valid", {63'h0, mem_req_valid}, 64'h0);
        chk("R1 done/fault", {62'h0, done, fault}, 64'h0);
    endtask

    task automatic t_unmapped();
        clear_mem();
        walk(64'h12_3000, 1'b0, 1'b0);
        expect_fault("R5 empty top", 32'h4000_0000, 1);
        chk("R4 top addr", first_addr, ROOT_BASE);
        chk("R11 fault_addr", r_faddr, 64'h12_3000);
    endtask

    task automatic t_basic();
        clear_mem();
        map(64'h12_4000, 64'h4000, P_DFLT);
        walk(64'h12_4108, 1'b0, 1'b0);
        chk("R8 done", {63'h0, r_done}, 64'h1);
        chk("R8 leaf_pte", r_pte, 64'hc000_0000_0000_4186);
        chk("R8 phys_addr", r_pa, 64'h4108);
        chk("R6 leaf addr", last_addr, 64'h1_2920);
        chk("R12 reads", 64'(nreads), 64'd2);
        map(64'h112_4000, 64'h4000, P_DFLT);
        walk(64'h112_4108, 1'b1, 1'b0);
        chk("R4 top addr idx8", first_addr, 64'h1_0040);
        chk("R6 second table", last_addr, 64'h1_3920);
        chk("R8 alias store pa", r_pa, 64'h4108);
        walk(64'h12_4108, 1'b0, 1'b0);
        chk("R8 first mapping kept", {63'h0, r_done}, 64'h1);
        chk("R13 idle after done", {63'h0, r_after_ok}, 64'h1);
    endtask

    task automatic t_unmap();
        clear_mem();
        map(64'h12_4000, 64'h4000, P_DFLT);
        put(64'h1_2920, 64'h0);
        walk(64'h12_4000, 1'b0, 1'b0);
        expect_fault("R7 zero leaf", 32'h4000_0000, 2);
        walk(64'h12_4000, 1'b1, 1'b0);
        expect_fault("R11 zero leaf store", 32'h4200_0000, 2);
        chk("R13 idle after fault", {63'h0, r_after_ok}, 64'h1);
    endtask

    task automatic t_perm();
        clear_mem();
        map(64'h12_4000, 64'h4000, 64'h18e);
        walk(64'h12_4000, 1'b0, 1'b0);
        expect_fault("R9 priv page user", 32'h0800_0000, 2);
        walk(64'h12_4000, 1'b0, 1'b1);
        chk("R9 priv page priv", {63'h0, r_done}, 64'h1);
        clear_mem();
        map(64'h12_4000, 64'h4000, 64'h104);
        walk(64'h12_4000, 1'b1, 1'b0);
        expect_fault("R9 read-only store", 32'h0a00_0000, 2);
        walk(64'h12_4000, 1'b0, 1'b0);
        chk("R9 read-only load", {63'h0, r_done}, 64'h1);
        clear_mem();
        map(64'h12_4000, 64'h4000, 64'h100);
        walk(64'h12_4000, 1'b0, 1'b0);
        expect_fault("R9 no access load", 32'h0800_0000, 2);
    endtask

    task automatic t_refchg();
        clear_mem();
        map(64'h12_4000, 64'h4000, 64'h006);
        walk(64'h12_4000, 1'b0, 1'b0);
        expect_fault("R10 no ref load", 32'h0004_0000, 2);
        walk(64'h12_4000, 1'b1, 1'b0);
        expect_fault("R10 no ref store", 32'h0204_0000, 2);
        clear_mem();
        map(64'h12_4000, 64'h4000, 64'h106);
        walk(64'h12_4000, 1'b0, 1'b0);
        chk("R10 ref load ok", {63'h0, r_done}, 64'h1);
        walk(64'h12_4000, 1'b1, 1'b0);
        expect_fault("R10 no chg store", 32'h0204_0000, 2);
        clear_mem();
        map(64'h12_4000, 64'h4000, 64'h080);
        walk(64'h12_4000, 1'b0, 1'b0);
        expect_fault("R10 perm first", 32'h0800_0000, 2);
    endtask

    task automatic t_root();
        clear_mem();
        map(64'h12_4000, 64'h4000, P_DFLT);
        root_cfg = ROOT_BASE | 64'd9;
        walk(64'h12_4000, 1'b0, 1'b0);
        expect_fault("R2 bad size", 32'h4000_0000, 0);
        root_cfg = ROOT_BASE | 64'd10 | 64'h20;
        walk(64'h12_4000, 1'b1, 1'b0);
        expect_fault("R2 bad class", 32'h4200_0000, 0);
        root_cfg = ROOT_BASE | 64'd10;
    endtask

    task automatic t_range();
        clear_mem();
        walk(64'h8000_0000, 1'b0, 1'b0);
        expect_fault("R3 above 2GB", 32'h4000_0000, 0);
        chk("R3 fault_addr", r_faddr, 64'h8000_0000);
        walk(64'hffff_0000_0000_1000, 1'b1, 1'b0);
        expect_fault("R3 high store", 32'h4200_0000, 0);
    endtask

    task automatic t_top_bad();
        clear_mem();
        put(ROOT_BASE, 64'hc000_0000_0001_2009);
        walk(64'h4000, 1'b0, 1'b0);
        expect_fault("R5 leaf at top", 32'h4000_0000, 1);
        put(ROOT_BASE, 64'h8000_0000_0001_2008);
        walk(64'h4000, 1'b0, 1'b0);
        expect_fault("R5 size not 9", 32'h4000_0000, 1);
        put(ROOT_BASE, 64'h8000_0000_0001_2009);
        put(64'h1_2020, 64'h8000_0000_0000_5009);
        walk(64'h4000, 1'b0, 1'b0);
        expect_fault("R7 non-leaf second", 32'h4000_0000, 2);
    endtask

    task automatic t_stall();
        clear_mem();
        map(64'h12_4000, 64'h4000, P_DFLT);
        stall_left = 3;
        walk(64'h12_4010, 1'b0, 1'b0);
        chk("R12 stall done", {63'h0, r_done}, 64'h1);
        chk("R12 stalled addr", stall_addr, ROOT_BASE);
        chk("R12 accepted addr", first_addr, ROOT_BASE);
        chk("R12 stall reads", 64'(nreads), 64'd2);
        chk("R12 stall pa", r_pa, 64'h4010);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_ea = '0; req_store = 1'b0; req_priv = 1'b0;
        root_cfg = ROOT_BASE | 64'd10;
        next_tbl = 64'h1_2000;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unmapped();
        t_basic();
        t_unmap();
        t_perm();
        t_refchg();
        t_root();
        t_range();
        t_top_bad();
        t_stall();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule